// File: doc/BRIEF.md
# Power-Loss Recovery and Sleep Controller

This block decides whether the system power supply is switched on once the auxiliary rail comes back after a loss. It holds one 8-bit control/status byte that software reads and writes through a simple strobe port. A single power-on-reset pulse from the auxiliary rail starts an evaluation. The outcome depends on the programmed restore policy, which is one of forced on, forced off, or return to the last state. A power-button override can block a forced power-up. Software can also force the supply off at any time by writing the self-clearing soft-off bit.

The same byte steers two classes of events. A sleep-enable write strobe either requests the sleep sequence or is diverted into an SMI. An enabled SCI-class event raises an SMI only when SCI delivery is off and that route has not been suppressed. Every SMI also needs the global SMI enable.

The power sequencer is a three-state machine. `ST_OFF` means the supply is disabled. `ST_EVAL` is the one-cycle decision state entered on a rail reset, and the supply stays disabled while in it. `ST_ON` means the supply is enabled. The transitions are as follows:
- `ST_OFF`→`ST_EVAL` and `ST_ON`→`ST_EVAL` on a rail reset pulse.
- `ST_EVAL`→`ST_ON` or `ST_EVAL`→`ST_OFF` by the restore policy.
- `ST_EVAL`→`ST_EVAL` when another rail reset arrives.
- Any state→`ST_OFF` on a soft-off write, which has the highest priority.

Top module: `pwr_restore_ctl`

## Requirements
- R1: After reset, supply_en_n is 1, sleep_req and smi_pulse are 0, reg_rdata is 8'h00 and wake_ctl is 0.
- R2: With bit 2 (force-on) set and bit 1 clear, a rail reset pulse sampled at edge k holds supply_en_n at 1 after edge k. If pbo_sts is 0 at edge k+1, supply_en_n becomes 0 after edge k+1.
- R3: With force-on the only policy bit, pbo_sts at 1 during the decision edge keeps supply_en_n at 1.
- R4: With bits 1 and 2 both clear, supply_en_n after the decision edge is the inverse of prior_on sampled at that edge.
- R5: Bit 1 (force-off) set makes the decision land in ST_OFF (supply_en_n 1), even when bit 2 is also set.
- R6: Status bit 3 is set by a rail reset pulse and cleared by a register write with bit 3 at 1. A write with bit 3 at 0 leaves it unchanged. A pulse and a clearing write on the same edge leave it set.
- R7: A register write with bit 7 at 1 sets supply_en_n to 1 after that edge, from any state. Bit 7 always reads back 0, and a write with bit 7 at 0 leaves the supply state unchanged.
- R8: A sleep-enable strobe at edge k gives sleep_req at 1 for the cycle after edge k when bit 5 is 0. When bit 5 is 1, it gives no sleep_req and an SMI pulse instead.
- R9: An SCI event at edge k gives smi_pulse at 1 after edge k only when sci_en is 0 and bit 6 is 0.
- R10: No smi_pulse is produced unless smi_gbl_en is 1 at the triggering edge.
- R11: Bits 1, 2, 4, 5 and 6 read back as last written, and bits 0 and 7 read 0. Bit 4 drives wake_ctl.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Write strobe for the control/status byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Readback of the control/status byte |
| aux_por | input | 1 | One-cycle auxiliary-rail power-on reset pulse |
| pbo_sts | input | 1 | Power-button override status |
| prior_on | input | 1 | Remembered supply state before the loss (1 = on) |
| sci_en | input | 1 | SCI delivery enabled |
| smi_gbl_en | input | 1 | Global SMI enable |
| slp_en_wr | input | 1 | Sleep-enable write strobe |
| sci_evt | input | 1 | Enabled SCI-class event strobe |
| supply_en_n | output | 1 | Active-low power-supply enable |
| sleep_req | output | 1 | One-cycle sleep sequence request |
| smi_pulse | output | 1 | One-cycle SMI pulse |
| wake_ctl | output | 1 | Wake-status set enable passed through from bit 4 |

## Verification
Register writes, status updates, soft-off, sleep_req and smi_pulse all show up right after the edge that samples the stimulus. A rail reset is the exception, because its effect on the supply shows one edge later, after the ST_EVAL cycle. The bench drives inputs just after a rising edge and samples one time unit after the next rising edge. A per-cycle reference model, written from the requirements, predicts each output for exactly that sample point. Directed sequences cover the two-edge restore path and the priority cases.

// File: rtl/pwr_restore_pkg.sv
package pwr_restore_pkg;
    localparam int REG_W  = 8;
    localparam int B_FOFF = 1;
    localparam int B_FON  = 2;
    localparam int B_STS  = 3;
    localparam int B_WAKE = 4;
    localparam int B_SDIV = 5;
    localparam int B_SSUP = 6;
    localparam int B_SOFF = 7;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_EVAL = 2'd1,
        ST_ON   = 2'd2
    } pwr_state_t;

    typedef struct packed {
        logic force_off;
        logic force_on;
        logic wake_ctl;
        logic slp_divert;
        logic smi_suppress;
    } ctl_t;
endpackage

// File: rtl/pwr_ctl_regs.sv
module pwr_ctl_regs
    import pwr_restore_pkg::*;
#(
    parameter int DW = REG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          por,
    output ctl_t          ctl,
    output logic          sts,
    output logic          soft_off,
    output logic [DW-1:0] rdata
);
    ctl_t ctl_q;
    logic sts_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr) begin
            ctl_q.force_off    <= wdata[B_FOFF];
            ctl_q.force_on     <= wdata[B_FON];
            ctl_q.wake_ctl     <= wdata[B_WAKE];
            ctl_q.slp_divert   <= wdata[B_SDIV];
            ctl_q.smi_suppress <= wdata[B_SSUP];
        end
    end

    // hardware set wins over software clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_q <= 1'b0;
        end else if (por) begin
            sts_q <= 1'b1;
        end else if (wr && wdata[B_STS]) begin
            sts_q <= 1'b0;
        end
    end

    always_comb begin
        rdata         = '0;
        rdata[B_FOFF] = ctl_q.force_off;
        rdata[B_FON]  = ctl_q.force_on;
        rdata[B_STS]  = sts_q;
        rdata[B_WAKE] = ctl_q.wake_ctl;
        rdata[B_SDIV] = ctl_q.slp_divert;
        rdata[B_SSUP] = ctl_q.smi_suppress;
    end

    assign ctl      = ctl_q;
    assign sts      = sts_q;
    assign soft_off = wr & wdata[B_SOFF];

    assert_sts_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        por |=> sts);
    assert_sts_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!por && !(wr && wdata[B_STS])) |=> $stable(sts));
    assert_ctl_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(ctl));
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import pwr_restore_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic por,
    input  logic soft_off,
    input  ctl_t ctl,
    input  logic pbo_sts,
    input  logic prior_on,
    output logic supply_en_n
);
    pwr_state_t state_q, state_d;
    logic       policy_on;

    always_comb begin
        if (ctl.force_off) begin
            policy_on = 1'b0;
        end else if (ctl.force_on) begin
            policy_on = !pbo_sts;
        end else begin
            policy_on = prior_on;
        end
    end

    always_comb begin
        state_d = state_q;
        if (soft_off) begin
            state_d = ST_OFF;
        end else if (por) begin
            state_d = ST_EVAL;
        end else begin
            unique case (state_q)
                ST_OFF:  state_d = ST_OFF;
                ST_EVAL: state_d = policy_on ? ST_ON : ST_OFF;
                ST_ON:   state_d = ST_ON;
                default: state_d = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_ON:   supply_en_n = 1'b0;
            ST_EVAL: supply_en_n = 1'b1;
            default: supply_en_n = 1'b1;
        endcase
    end

    assert_softoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
        soft_off |=> supply_en_n);
    assert_forceoff_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVAL && !por && !soft_off && ctl.force_off) |=> supply_en_n);
    assert_pbo_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVAL && !por && !soft_off && ctl.force_on && pbo_sts) |=> supply_en_n);
    assert_por_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (por && !soft_off) |=> (state_q == ST_EVAL));
endmodule

// File: rtl/pwr_evt_route.sv
module pwr_evt_route (
    input  logic clk,
    input  logic rst_n,
    input  logic slp_wr,
    input  logic sci_evt,
    input  logic sci_en,
    input  logic smi_gbl_en,
    input  logic slp_divert,
    input  logic smi_suppress,
    output logic sleep_req,
    output logic smi_pulse
);
    logic slp_smi, sci_smi;
    logic sleep_q, smi_q;

    assign slp_smi = slp_wr & slp_divert;
    assign sci_smi = sci_evt & !sci_en & !smi_suppress;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sleep_q <= 1'b0;
            smi_q   <= 1'b0;
        end else begin
            sleep_q <= slp_wr & !slp_divert;
            smi_q   <= smi_gbl_en & (slp_smi | sci_smi);
        end
    end

    assign sleep_req = sleep_q;
    assign smi_pulse = smi_q;

    assert_smi_gbl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        smi_pulse |-> $past(smi_gbl_en));
    assert_sleep_divert_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |-> !$past(slp_divert));
    assert_sci_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sci_evt && sci_en && !slp_wr) |=> !smi_pulse);
endmodule

// File: rtl/pwr_restore_ctl.sv
module pwr_restore_ctl
    import pwr_restore_pkg::*;
#(
    parameter int DW = REG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          aux_por,
    input  logic          pbo_sts,
    input  logic          prior_on,
    input  logic          sci_en,
    input  logic          smi_gbl_en,
    input  logic          slp_en_wr,
    input  logic          sci_evt,
    output logic          supply_en_n,
    output logic          sleep_req,
    output logic          smi_pulse,
    output logic          wake_ctl
);
    ctl_t ctl;
    logic sts;
    logic soft_off;

    pwr_ctl_regs #(.DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .wdata    (reg_wdata),
        .por      (aux_por),
        .ctl      (ctl),
        .sts      (sts),
        .soft_off (soft_off),
        .rdata    (reg_rdata)
    );

    pwr_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .por         (aux_por),
        .soft_off    (soft_off),
        .ctl         (ctl),
        .pbo_sts     (pbo_sts),
        .prior_on    (prior_on),
        .supply_en_n (supply_en_n)
    );

    pwr_evt_route u_route (
        .clk          (clk),
        .rst_n        (rst_n),
        .slp_wr       (slp_en_wr),
        .sci_evt      (sci_evt),
        .sci_en       (sci_en),
        .smi_gbl_en   (smi_gbl_en),
        .slp_divert   (ctl.slp_divert),
        .smi_suppress (ctl.smi_suppress),
        .sleep_req    (sleep_req),
        .smi_pulse    (smi_pulse)
    );

    assign wake_ctl = ctl.wake_ctl;

    assert_sts_visible_R6: assert property (@(posedge clk) disable iff (!rst_n)
        aux_por |=> reg_rdata[B_STS]);
endmodule

// File: tb/pwr_restore_ctl_bench.sv
`timescale 1ns/1ps
module pwr_restore_ctl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       aux_por = 1'b0, pbo_sts = 1'b0, prior_on = 1'b0;
    logic       sci_en = 1'b0, smi_gbl_en = 1'b0, slp_en_wr = 1'b0, sci_evt = 1'b0;
    logic       supply_en_n, sleep_req, smi_pulse, wake_ctl;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // reference model state
    logic m_on, m_eval, m_foff, m_fon, m_sts, m_wake, m_div, m_sup, m_sleep, m_smi;

    always #2.5 clk = ~clk;

    pwr_restore_ctl u_pwr_restore_ctl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .aux_por(aux_por), .pbo_sts(pbo_sts),
        .prior_on(prior_on), .sci_en(sci_en), .smi_gbl_en(smi_gbl_en),
        .slp_en_wr(slp_en_wr), .sci_evt(sci_evt), .supply_en_n(supply_en_n),
        .sleep_req(sleep_req), .smi_pulse(smi_pulse), .wake_ctl(wake_ctl)
    );

    function automatic logic [7:0] exp_rdata();
        return {1'b0, m_sup, m_div, m_wake, m_sts, m_fon, m_foff, 1'b0};
    endfunction

    function automatic logic restore_policy(input logic foff, input logic fon,
                                            input logic pbo, input logic prior);
        if (foff) return 1'b0;
        if (fon)  return !pbo;
        return prior;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_all();
        chk("R2/R3/R4/R5/R7 supply_en_n", {7'd0, supply_en_n}, {7'd0, !m_on});
        chk("R6/R11 reg_rdata", reg_rdata, exp_rdata());
        chk("R11 wake_ctl", {7'd0, wake_ctl}, {7'd0, m_wake});
        chk("R8 sleep_req", {7'd0, sleep_req}, {7'd0, m_sleep});
        chk("R8/R9/R10 smi_pulse", {7'd0, smi_pulse}, {7'd0, m_smi});
    endtask

    task automatic step(input logic wr, input logic [7:0] wd, input logic por,
                        input logic pbo, input logic prior, input logic scien,
                        input logic gbl, input logic slp, input logic sci);
        logic n_on, n_eval;
        reg_wr = wr; reg_wdata = wd; aux_por = por; pbo_sts = pbo; prior_on = prior;
        sci_en = scien; smi_gbl_en = gbl; slp_en_wr = slp; sci_evt = sci;
        @(posedge clk);
        #1;
        n_on = m_on; n_eval = m_eval;
        if (wr && wd[7]) begin
            n_on = 1'b0; n_eval = 1'b0;
        end else if (por) begin
            n_on = 1'b0; n_eval = 1'b1;
        end else if (m_eval) begin
            n_eval = 1'b0;
            n_on = restore_policy(m_foff, m_fon, pbo, prior);
        end
        m_sleep = slp & !m_div;
        m_smi   = gbl & ((slp & m_div) | (sci & !scien & !m_sup));
        if (por) m_sts = 1'b1;
        else if (wr && wd[3]) m_sts = 1'b0;
        if (wr) begin
            m_foff = wd[1]; m_fon = wd[2]; m_wake = wd[4]; m_div = wd[5]; m_sup = wd[6];
        end
        m_on = n_on; m_eval = n_eval;
        reg_wr = 1'b0; aux_por = 1'b0; slp_en_wr = 1'b0; sci_evt = 1'b0;
        check_all();
    endtask

    task automatic idle();
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        {m_on, m_eval, m_foff, m_fon, m_sts, m_wake, m_div, m_sup, m_sleep, m_smi} = '0;
        void'($urandom(32'd20240607));
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 supply_en_n", {7'd0, supply_en_n}, 8'h01);
        chk("R1 rdata", reg_rdata, 8'h00);
        chk("R1 pulses", {6'd0, sleep_req, smi_pulse}, 8'h00);
        rst_n = 1'b1;
        idle();

        // R2 forced on
        step(1, 8'h04, 0, 0, 0, 0, 0, 0, 0);
        step(0, 8'h00, 1, 0, 0, 0, 0, 0, 0);
        chk("R2 supply off during decision", {7'd0, supply_en_n}, 8'h01);
        idle();
        chk("R2 supply on", {7'd0, supply_en_n}, 8'h00);
        chk("R6 status set", reg_rdata, 8'h0C);

        // R6 write-one-to-clear
        step(1, 8'h04, 0, 0, 0, 0, 0, 0, 0);
        chk("R6 write 0 keeps status", reg_rdata, 8'h0C);
        step(1, 8'h0C, 0, 0, 0, 0, 0, 0, 0);
        chk("R6 write 1 clears status", reg_rdata, 8'h04);
        step(1, 8'h0C, 1, 0, 0, 0, 0, 0, 0);
        chk("R6 set wins over clear", reg_rdata & 8'h08, 8'h08);
        idle();

        // R7 soft-off
        chk("R7 on before soft-off", {7'd0, supply_en_n}, 8'h00);
        step(1, 8'h04, 0, 0, 0, 0, 0, 0, 0);
        chk("R7 write 0 no effect", {7'd0, supply_en_n}, 8'h00);
        step(1, 8'h84, 0, 0, 0, 0, 0, 0, 0);
        chk("R7 soft-off", {7'd0, supply_en_n}, 8'h01);
        chk("R7 bit7 reads 0", reg_rdata & 8'h80, 8'h00);

        // R3 override blocks forced on
        step(0, 8'h00, 1, 1, 1, 0, 0, 0, 0);
        step(0, 8'h00, 0, 1, 1, 0, 0, 0, 0);
        chk("R3 blocked", {7'd0, supply_en_n}, 8'h01);

        // R5 force-off wins
        step(1, 8'h06, 0, 0, 1, 0, 0, 0, 0);
        step(0, 8'h00, 1, 0, 1, 0, 0, 0, 0);
        step(0, 8'h00, 0, 0, 1, 0, 0, 0, 0);
        chk("R5 force-off priority", {7'd0, supply_en_n}, 8'h01);

        // R4 last state
        step(1, 8'h00, 0, 0, 0, 0, 0, 0, 0);
        step(0, 8'h00, 1, 0, 1, 0, 0, 0, 0);
        step(0, 8'h00, 0, 1, 1, 0, 0, 0, 0);
        chk("R4 restore on", {7'd0, supply_en_n}, 8'h00);
        step(0, 8'h00, 1, 0, 0, 0, 0, 0, 0);
        step(0, 8'h00, 0, 0, 0, 0, 0, 0, 0);
        chk("R4 restore off", {7'd0, supply_en_n}, 8'h01);

        // R8 sleep versus SMI
        step(0, 8'h00, 0, 0, 0, 0, 1, 1, 0);
        chk("R8 sleep req", {6'd0, sleep_req, smi_pulse}, 8'h02);
        step(1, 8'h20, 0, 0, 0, 0, 0, 0, 0);
        step(0, 8'h00, 0, 0, 0, 0, 1, 1, 0);
        chk("R8 diverted to SMI", {6'd0, sleep_req, smi_pulse}, 8'h01);
        step(0, 8'h00, 0, 0, 0, 0, 0, 1, 0);
        chk("R10 no SMI without global", {6'd0, sleep_req, smi_pulse}, 8'h00);

        // R9 SCI events
        step(1, 8'h00, 0, 0, 0, 0, 0, 0, 0);
        step(0, 8'h00, 0, 0, 0, 0, 1, 0, 1);
        chk("R9 sci smi", {7'd0, smi_pulse}, 8'h01);
        step(0, 8'h00, 0, 0, 0, 1, 1, 0, 1);
        chk("R9 sci_en blocks", {7'd0, smi_pulse}, 8'h00);
        step(1, 8'h40, 0, 0, 0, 0, 0, 0, 0);
        step(0, 8'h00, 0, 0, 0, 0, 1, 0, 1);
        chk("R9 suppressed", {7'd0, smi_pulse}, 8'h00);

        // R11 readback
        step(1, 8'h72, 0, 0, 0, 0, 0, 0, 0);
        chk("R11 readback", reg_rdata & 8'hF7, 8'h72);
        chk("R11 wake_ctl", {7'd0, wake_ctl}, 8'h01);
        step(1, 8'hFF, 0, 0, 0, 0, 0, 0, 0);
        chk("R11 bits 0 and 7 read 0", reg_rdata, 8'h76);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] wd;
            logic wr, por;
            wr  = ($urandom % 4) == 0;
            wd  = 8'($urandom);
            if (($urandom % 8) != 0) wd[7] = 1'b0;
            por = ($urandom % 12) == 0;
            step(wr, wd, por, 1'($urandom), 1'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom), 1'($urandom));
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end
endmodule